// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block is a clause-22 management-bus master that software drives through four 32-bit registers on a simple word-access bus. Software first programs a command register with a PHY address, a register number and an operation code. For a write it also loads a 16-bit data word. It then writes 1 to the operation register. The master emits one complete frame on MDC/MDIO, and the operation register drops back to 0 when the frame has ended.

A read frame's result lands in the read-data register at the same clock edge that the operation register returns to idle. Software therefore polls for idle once before programming a new command, and polls again before collecting read data. MDC is produced by dividing the system clock and runs only while a frame is in flight. MDIO is updated on MDC falling edges and sampled on MDC rising edges. The master releases the line for the turnaround and data of a read.

Top module: `mdio_master_regs`

## Requirements
- R1: Register byte offsets are 0 (operation), 4 (command), 8 (write data), 12 (read data). In the command register, bits 25:21 hold the PHY address, bits 20:16 the register number and bits 3:2 the operation code; these read back and every other command bit reads 0. Write data and read data occupy bits 15:0, and their upper bits read 0.
- R2: Writing a value with bit 0 set to the operation register while idle, with operation code 1 (write) or 2 (read), starts a frame. The operation register reads 1 from the next cycle until the frame ends and 0 afterwards. Writing 0 starts nothing.
- R3: A start request is ignored when the operation code is 0 or 3. The operation register stays 0 and MDC stays low.
- R4: A start written while busy is ignored, and command or write-data writes made while busy do not alter the frame in flight. Every frame is exactly PRE_BITS+32 MDC cycles.
- R5: A write frame carries PRE_BITS ones, then 01, 01, the PHY address MSB first, the register number MSB first, 10 and the 16 write-data bits MSB first, with MDIO driven throughout.
- R6: A read frame carries the same preamble and start bits, then opcode 10, the PHY address and the register number. The master then releases MDIO (output enable 0) for the two turnaround bits and all 16 data bits.
- R7: Read data is sampled on MDC rising edges during the 16 data bits, MSB first. It is placed in the read-data register when the frame ends. A write frame leaves the read-data register unchanged.
- R8: MDC has a period of 2*CLK_DIV system clocks while busy and is low while idle. MDIO changes only on MDC falling edges, so it is stable at each rising edge.
- R9: After reset the operation, command, write-data and read-data registers read 0, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write when high |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational from addr_i) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line input |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
The bench builds the block with CLK_DIV=2 and the default 32-bit preamble. Each bit then lasts four system clocks and a full frame takes 256, which makes it affordable to sweep all 32 PHY addresses through both a write frame and a read frame. A bus model answers reads with computed words, so every address and register field, the turnaround release and the MSB-first read path are covered against arithmetic expectations. The small divider also keeps the busy-time checks short: the restart attempt, the mid-frame command rewrite and the per-bit MDC period measurement.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_OP    = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_WDATA = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_RDATA = 4'hC;

  typedef enum logic [1:0] {
    OPC_NONE = 2'd0,
    OPC_WR   = 2'd1,
    OPC_RD   = 2'd2,
    OPC_RSV  = 2'd3
  } opc_e;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regad;
    opc_e       opc;
  } xfer_cmd_t;
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              rd_done_i,
  input  logic [15:0]       rd_data_i,
  output logic              start_o,
  output xfer_cmd_t         cmd_o,
  output logic [15:0]       wr_data_o
);
  xfer_cmd_t   cmd_q;
  logic [15:0] wdata_q, rdata_q;
  logic        wr_acc, opc_ok;

  assign wr_acc    = req_i & we_i;
  assign opc_ok    = (cmd_q.opc == OPC_WR) || (cmd_q.opc == OPC_RD);
  assign start_o   = wr_acc && (addr_i == OFS_OP) && wdata_i[0] && !busy_i && opc_ok;
  assign cmd_o     = cmd_q;
  assign wr_data_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '{phy: 5'd0, regad: 5'd0, opc: OPC_NONE};
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_acc && addr_i == OFS_CMD) begin
        cmd_q.phy   <= wdata_i[25:21];
        cmd_q.regad <= wdata_i[20:16];
        cmd_q.opc   <= opc_e'(wdata_i[3:2]);
      end
      if (wr_acc && addr_i == OFS_WDATA) wdata_q <= wdata_i[15:0];
      if (rd_done_i) rdata_q <= rd_data_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_OP:    rdata_o = {31'd0, busy_i};
      OFS_CMD:   rdata_o = {6'd0, cmd_q.phy, cmd_q.regad, 12'd0, cmd_q.opc, 2'd0};
      OFS_WDATA: rdata_o = {16'd0, wdata_q};
      OFS_RDATA: rdata_o = {16'd0, rdata_q};
      default:   rdata_o = '0;
    endcase
  end

  // accepted start must raise busy on the next cycle
  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_i);
  // bad opcode never launches a frame
  assert_bad_opc_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !opc_ok) |=> !busy_i);
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q, tick;

  assign tick   = run_i && (cnt_q == CNT_MAX);
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick &  mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  xfer_cmd_t   cmd_i,
  input  logic [15:0] wr_data_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        rd_done_o,
  output logic [15:0] rd_data_o
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_IDX  = CNT_W'(PRE_BITS);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(PRE_BITS + 14);
  localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(PRE_BITS + 16);

  logic [CNT_W-1:0] bit_cnt_q, nxt_cnt;
  logic             busy_q, is_rd_q, mdio_q, oe_q;
  logic [31:0]      sh_q, payload;
  logic [15:0]      rd_sh_q;
  logic             is_rd_cmd, last_bit, in_hdr;

  always_comb begin
    is_rd_cmd = (cmd_i.opc == OPC_RD);
    payload   = {2'b01, (is_rd_cmd ? 2'b10 : 2'b01), cmd_i.phy, cmd_i.regad,
                 (is_rd_cmd ? 2'b11 : 2'b10), (is_rd_cmd ? 16'hFFFF : wr_data_i)};
    last_bit  = (bit_cnt_q == LAST_IDX);
    nxt_cnt   = bit_cnt_q + 1'b1;
    in_hdr    = (bit_cnt_q >= HDR_IDX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      is_rd_q   <= 1'b0;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      mdio_q    <= 1'b1;
      oe_q      <= 1'b0;
      rd_sh_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q    <= 1'b1;
      is_rd_q   <= is_rd_cmd;
      bit_cnt_q <= '0;
      sh_q      <= payload;
      mdio_q    <= 1'b1;  // first preamble bit
      oe_q      <= 1'b1;
    end else if (busy_q) begin
      if (rise_i && is_rd_q && bit_cnt_q >= DAT_IDX)
        rd_sh_q <= {rd_sh_q[14:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q    <= 1'b0;
          oe_q      <= 1'b0;
          mdio_q    <= 1'b1;
          bit_cnt_q <= '0;
        end else begin
          bit_cnt_q <= nxt_cnt;
          if (in_hdr) sh_q <= {sh_q[30:0], 1'b0};
          mdio_q <= (nxt_cnt < HDR_IDX) ? 1'b1 : (in_hdr ? sh_q[30] : sh_q[31]);
          oe_q   <= !(is_rd_q && nxt_cnt >= TA_IDX);
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  assign rd_done_o = busy_q & fall_i & last_bit & is_rd_q;
  assign rd_data_o = rd_sh_q;

  // read frames leave the line released from turnaround to the end
  assert_ta_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && is_rd_q && bit_cnt_q >= TA_IDX) |-> !oe_q);
  assert_oe_only_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> busy_q);
  // a start seen mid-frame must not rewind the bit position
  assert_no_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !fall_i) |=> (bit_cnt_q == $past(bit_cnt_q)));
endmodule

// File: rtl/mdio_master_regs.sv
module mdio_master_regs
  import mdio_pkg::*;
#(
  parameter int CLK_DIV  = 2,
  parameter int PRE_BITS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              mdc_o,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  logic        busy, start, rd_done, rise, fall;
  xfer_cmd_t   cmd;
  logic [15:0] wr_data, rd_data;

  mdio_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .rd_done_i(rd_done), .rd_data_i(rd_data),
    .start_o(start), .cmd_o(cmd), .wr_data_o(wr_data)
  );

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk_i, .rst_ni, .run_i(busy), .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame #(.PRE_BITS(PRE_BITS)) u_frame (
    .clk_i, .rst_ni, .start_i(start), .cmd_i(cmd), .wr_data_i(wr_data),
    .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .mdio_o, .mdio_oe_o, .rd_done_o(rd_done), .rd_data_o(rd_data)
  );

  assert_mdc_idle_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> !mdc_o);
  assert_mdio_stable_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $stable(mdio_o));
endmodule

// File: tb/tb_mdio_master_regs.sv
`timescale 1ns/1ps
module tb_mdio_master_regs;
  localparam int CLK_DIV = 2;
  localparam int PRE     = 32;
  localparam int NBITS   = PRE + 32;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic mdc, mdio_in = 1, mdio_out, mdio_oe;

  int checks = 0, fails = 0;
  int rise_n = 0, per_err = 0;
  realtime last_rise = 0;
  logic [NBITS-1:0] cap_bits = 0, cap_oe = 0;
  logic [15:0] phy_val = 0;

  always #2.5 clk = ~clk;

  mdio_master_regs #(.CLK_DIV(CLK_DIV), .PRE_BITS(PRE)) dut (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .mdc_o(mdc), .mdio_i(mdio_in), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  // bus monitor: capture at rising MDC, check period (R8)
  always @(posedge mdc) begin
    #1;
    cap_bits = {cap_bits[NBITS-2:0], mdio_out};
    cap_oe   = {cap_oe[NBITS-2:0], mdio_oe};
    if (rise_n > 0 && ($realtime - last_rise) != 2.0 * CLK_DIV * 5.0) per_err++;
    last_rise = $realtime;
    rise_n++;
  end

  // PHY model: drive next bit after falling MDC
  always @(negedge mdc) begin
    #1;
    if (rise_n >= PRE + 16 && rise_n < PRE + 32) mdio_in = phy_val[15 - (rise_n - PRE - 16)];
    else if (rise_n == PRE + 15) mdio_in = 1'b0;
    else mdio_in = 1'b1;
  end

  task automatic chk(input bit ok, input string req_s, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic [1:0] opc, input logic [4:0] phy, input logic [4:0] rg);
    return {6'd0, phy, rg, 12'd0, opc, 2'd0};
  endfunction

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(4'h0, v);
      if (v == 0) begin ok = 1; break; end
    end
  endtask

  // one frame with full checks; disturb=1 hits the block mid-frame (R4)
  task automatic frame(input bit is_rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input bit disturb);
    logic [31:0] v, prev_rd;
    logic [NBITS-1:0] exp_bits, exp_oe, msk;
    bit ok;
    rd(4'hC, prev_rd);
    wr(4'h4, cmd_word(is_rd ? 2'd2 : 2'd1, phy, rg));
    if (!is_rd) wr(4'h8, {16'hDEAD, d});
    phy_val = d;
    rise_n = 0;
    wr(4'h0, 32'h1);
    rd(4'h0, v);
    chk(v == 1, "R2 busy after start", v, 1);
    if (disturb) begin
      repeat (20) @(negedge clk);
      wr(4'h4, cmd_word(2'd2, ~phy, ~rg));
      wr(4'h8, {16'd0, ~d});
      wr(4'h0, 32'h1);
      rd(4'h0, v);
      chk(v == 1, "R4 still busy", v, 1);
    end
    wait_idle(ok);
    chk(ok, "R2 returns idle", ok, 1);
    chk(rise_n == NBITS, "R4 frame length", rise_n, NBITS);
    exp_bits = {{PRE{1'b1}}, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, rg,
                (is_rd ? 18'h3FFFF : {2'b10, d})};
    msk = is_rd ? {{(PRE+14){1'b1}}, 18'd0} : '1;
    exp_oe = msk;
    if (is_rd) begin
      chk((cap_bits & msk) == (exp_bits & msk), "R6 read header", cap_bits, exp_bits);
      chk(cap_oe == exp_oe, "R6 release", cap_oe, exp_oe);
      rd(4'hC, v);
      chk(v == {16'd0, d}, "R7 read data", v, d);
    end else begin
      chk(cap_bits == exp_bits, "R5 write stream", cap_bits, exp_bits);
      chk(cap_oe == exp_oe, "R5 driven", cap_oe, exp_oe);
      rd(4'hC, v);
      chk(v == prev_rd, "R7 write keeps rdata", v, prev_rd);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R9 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      chk(v == 0, "R9 reg reset", v, 0);
    end
    chk(mdc == 0 && mdio_oe == 0, "R9 pins idle", {mdc, mdio_oe}, 0);

    // R1 field placement and readback
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v);
    chk(v == 32'h03FF_000C, "R1 cmd readback", v, 32'h03FF_000C);
    wr(4'h8, 32'h1234_ABCD);
    rd(4'h8, v);
    chk(v == 32'h0000_ABCD, "R1 wdata readback", v, 32'h0000_ABCD);

    // R3 bad opcodes ignored (3 then 0)
    rise_n = 0;
    wr(4'h0, 32'h1);
    rd(4'h0, v);
    chk(v == 0, "R3 opc3 ignored", v, 0);
    wr(4'h4, cmd_word(2'd0, 5'd3, 5'd4));
    wr(4'h0, 32'h1);
    rd(4'h0, v);
    chk(v == 0, "R3 opc0 ignored", v, 0);
    repeat (20) @(negedge clk);
    chk(rise_n == 0 && mdc == 0, "R3 no mdc", rise_n, 0);

    // R2 writing 0 does nothing
    wr(4'h4, cmd_word(2'd1, 5'd1, 5'd1));
    wr(4'h0, 32'h0);
    rd(4'h0, v);
    chk(v == 0, "R2 zero write", v, 0);

    // sweep all PHY addresses, write then read
    for (int p = 0; p < 32; p++) begin
      frame(1'b0, 5'(p), 5'((p * 7) % 32), 16'(p * 16'h0813) ^ 16'hA5C3, 1'b0);
      frame(1'b1, 5'(31 - p), 5'(p), ~16'(p * 16'h1111) + 16'(p), 1'b0);
    end
    chk(per_err == 0, "R8 mdc period", per_err, 0);

    // R4 disturbance during write and read frames
    frame(1'b0, 5'd10, 5'd21, 16'h8001, 1'b1);
    rd(4'h4, v);
    chk(v == cmd_word(2'd2, ~5'd10, ~5'd21), "R1 cmd updated while busy", v, cmd_word(2'd2, ~5'd10, ~5'd21));
    frame(1'b1, 5'd5, 5'd17, 16'h7FFE, 1'b1);
    chk(mdc == 0 && mdio_oe == 0, "R8 idle pins", {mdc, mdio_oe}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule